// File: doc/BRIEF.md
# Start/Stop Decade Counter with Interval Tick

This block counts from 0 to 9 at a slow, programmable rate and is started and stopped by two pulse inputs. An interval generator runs freely on the system clock. It raises a one-cycle tick every `TENTHS` tenths of a second. With the default 100 MHz clock and `TENTHS = 5`, the tick comes every half second. The decade count steps once on each tick, but only while an internal run flag is set.

The start and stop inputs are expected to be clean, already debounced single-cycle pulses. Start sets the run flag and stop clears it. The tick never drives a clock pin; every register sits on `clk_i`, and the tick is used only as an enable. The current digit is presented on `count_o`. The tick is also exported, so a display or other logic can work in step with it.

Top module: `decade_run_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` reads 0, `tick_o` reads 0 and the run flag is cleared. After reset is released, the counter is stopped until a start pulse arrives. Reset acts at once, without waiting for a clock edge.
- R2: The interval counter starts at 0 and increments on every clock edge. The interval limit is L = `TENTHS` × (`CLK_HZ`/10). `tick_o` is high exactly in the cycle where the interval counter equals L, and the counter returns to 0 on the next edge. The first tick therefore comes L cycles after reset release, and later ticks come every L+1 cycles, each one cycle wide.
- R3: While running, each tick increments `count_o` by one. The new value appears in the cycle after the tick cycle.
- R4: A tick taken while running with `count_o` = 9 gives `count_o` = 0 (modulus 10).
- R5: `count_o` does not change in any cycle except the one after a tick taken while running. In the stopped state, ticks leave it unchanged.
- R6: A start pulse sets the run flag and a stop pulse clears it. When both arrive in the same cycle, stop wins and the counter is stopped afterwards.
- R7: A start pulse in the same cycle as a tick takes effect on the same edge as the count. That tick is therefore not counted; the next tick is.
- R8: A stop pulse in the same cycle as a tick, while running, does not prevent that tick from being counted. Later ticks are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, default 100 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Debounced start pulse, sets run flag |
| stop_i | input | 1 | Debounced stop pulse, clears run flag (wins over start) |
| tick_o | output | 1 | One-cycle interval strobe |
| count_o | output | 4 | Current decade digit, 0 to 9 |

## Verification
The bench aims control pulses precisely at the cycle of a tick and at the cycles between ticks.

- A design that let start act one edge early would count the coinciding tick.
- One that let stop act early would drop a tick that should have been counted.
- A design that gave start priority would keep running after simultaneous pulses.

Tick spacing is measured from reset and between ticks. A limit compared off by one, or a wrong reload value, shows up as a wrong gap. The 9-to-0 wrap is crossed more than once. A reset issued in the middle of a run must clear the digit immediately and leave the counter stopped.

// File: rtl/decade_run_pkg.sv
package decade_run_pkg;

  typedef enum logic [1:0] {
    RUN_KEEP = 2'd0,
    RUN_SET  = 2'd1,
    RUN_CLR  = 2'd2
  } run_cmd_e;

  function automatic int unsigned interval_limit(int unsigned clk_hz, int unsigned tenths);
    return tenths * (clk_hz / 10);
  endfunction

endpackage

// File: rtl/interval_tick_gen.sv
module interval_tick_gen #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned TENTHS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  import decade_run_pkg::*;

  localparam int unsigned LIMIT = interval_limit(CLK_HZ, TENTHS);
  localparam int unsigned IW    = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [IW-1:0] ivl_q;
  logic          at_limit;

  assign at_limit = (ivl_q == IW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ivl_q <= '0;
    else if (at_limit) ivl_q <= '0;
    else               ivl_q <= ivl_q + IW'(1);
  end

  assign tick_o = at_limit & rst_ni;

endmodule

// File: rtl/run_flag_ctl.sv
module run_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);
  import decade_run_pkg::*;

  run_cmd_e cmd;
  logic     run_q;

  // stop has priority over start
  always_comb begin
    if (stop_i)       cmd = RUN_CLR;
    else if (start_i) cmd = RUN_SET;
    else              cmd = RUN_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else begin
      unique case (cmd)
        RUN_SET:  run_q <= 1'b1;
        RUN_CLR:  run_q <= 1'b0;
        default:  run_q <= run_q;
      endcase
    end
  end

  assign run_o = run_q;

endmodule

// File: rtl/mod_n_counter.sv
module mod_n_counter #(
  parameter int unsigned MODULUS = 10,
  localparam int unsigned CW     = (MODULUS < 2) ? 1 : $clog2(MODULUS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] count_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  generate
    if (MODULUS == (1 << CW)) begin : g_pow2
      assign cnt_inc = cnt_q + CW'(1);
    end else begin : g_cmp
      assign cnt_inc = (cnt_q == CW'(MODULUS - 1)) ? '0 : cnt_q + CW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_inc;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/decade_run_counter.sv
module decade_run_counter #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TENTHS  = 5,
  parameter int unsigned MODULUS = 10,
  localparam int unsigned CW     = (MODULUS < 2) ? 1 : $clog2(MODULUS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          tick_o,
  output logic [CW-1:0] count_o
);

  logic tick;
  logic run_q;
  logic cnt_en;

  interval_tick_gen #(
    .CLK_HZ (CLK_HZ),
    .TENTHS (TENTHS)
  ) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  run_flag_ctl i_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .run_o   (run_q)
  );

  // tick is an enable, not a clock
  assign cnt_en = tick & run_q;

  mod_n_counter #(
    .MODULUS (MODULUS)
  ) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en),
    .count_o (count_o)
  );

  assign tick_o = tick;

endmodule

// File: rtl/decade_run_checker.sv
module decade_run_checker #(
  parameter int unsigned MODULUS = 10,
  parameter int unsigned CW      = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_i,
  input logic          tick_o,
  input logic          run_q,
  input logic [CW-1:0] count_o
);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0) && !run_q && !tick_o);

  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && run_q && (count_o != CW'(MODULUS - 1))) |=> (count_o == $past(count_o) + CW'(1)));

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && run_q && (count_o == CW'(MODULUS - 1))) |=> (count_o == '0));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_o && run_q) |=> $stable(count_o));

  assert_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o < CW'(MODULUS));

  assert_stop_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);

  assert_start_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> run_q);

  assert_start_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && start_i && !run_q) |=> $stable(count_o));

  assert_stop_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && stop_i && run_q) |=> (count_o != $past(count_o)));

endmodule

bind decade_run_counter decade_run_checker #(
  .MODULUS (MODULUS),
  .CW      (CW)
) i_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .stop_i  (stop_i),
  .tick_o  (tick_o),
  .run_q   (run_q),
  .count_o (count_o)
);

// File: tb/test_decade_run_counter.sv
module test_decade_run_counter;
  localparam int unsigned CLK_HZ  = 100;
  localparam int unsigned TENTHS  = 3;
  localparam int unsigned MODULUS = 10;
  localparam int          LIMIT   = TENTHS * (CLK_HZ / 10);

  logic       clk_i   = 1'b0;
  logic       rst_ni  = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_i  = 1'b0;
  logic       tick_o;
  logic [3:0] count_o;

  always #10 clk_i = ~clk_i;

  decade_run_counter #(
    .CLK_HZ  (CLK_HZ),
    .TENTHS  (TENTHS),
    .MODULUS (MODULUS)
  ) i_decade_run_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .tick_o  (tick_o),
    .count_o (count_o)
  );

  typedef struct {
    logic [3:0] val;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  exp_t       got;
  int         checks   = 0;
  int         failures = 0;
  int         exp_cnt  = 0;
  bit         exp_run  = 1'b0;
  bit         tick_prev;
  bit         first_tick;
  int         since;
  logic [3:0] last_count;
  bit         done = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected digits after each tick, checks hold and spacing
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      tick_prev  = 1'b0;
      since      = 0;
      first_tick = 1'b1;
      last_count = count_o;
    end else begin
      since++;
      if (tick_prev) begin
        if (exp_q.size() == 0) check(1'b0, "R3", "no expectation queued", int'(count_o), -1);
        else begin
          got = exp_q.pop_front();
          check(count_o == got.val, got.tag, "digit after tick", int'(count_o), int'(got.val));
        end
      end else begin
        check(count_o == last_count, "R5", "digit held between ticks", int'(count_o), int'(last_count));
      end
      if (tick_o) begin
        check(since == (first_tick ? LIMIT : LIMIT + 1), "R2", "tick spacing", since,
              first_tick ? LIMIT : LIMIT + 1);
        since      = 0;
        first_tick = 1'b0;
      end
      tick_prev  = tick_o;
      last_count = count_o;
    end
  end

  // driver: acts in a tick cycle and pushes the expected digit
  task automatic step(bit st, bit sp, string tag);
    do @(negedge clk_i); while (!tick_o);
    start_i = st;
    stop_i  = sp;
    if (exp_run) exp_cnt = (exp_cnt + 1) % MODULUS;
    if (sp)      exp_run = 1'b0;
    else if (st) exp_run = 1'b1;
    exp_q.push_back('{val: 4'(exp_cnt), tag: tag});
    @(negedge clk_i);
    start_i = 1'b0;
    stop_i  = 1'b0;
  endtask

  // pulse away from a tick (called right after step)
  task automatic pulse(bit st, bit sp);
    start_i = st;
    stop_i  = sp;
    if (sp)      exp_run = 1'b0;
    else if (st) exp_run = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    stop_i  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    #5 rst_ni = 1'b0;
    #1;
    check(count_o == 4'd0, "R1", "digit in reset", int'(count_o), 0);
    check(tick_o == 1'b0, "R1", "tick in reset", int'(tick_o), 0);
    exp_q.delete();
    exp_cnt = 0;
    exp_run = 1'b0;
    repeat (3) @(negedge clk_i);
    check(count_o == 4'd0, "R1", "digit held in reset", int'(count_o), 0);
    #5 rst_ni = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check(count_o == 4'd0, "R1", "digit at power-up reset", int'(count_o), 0);
    check(tick_o == 1'b0, "R1", "tick at power-up reset", int'(tick_o), 0);
    #5 rst_ni = 1'b1;

    // stopped after reset: ticks ignored
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R5");

    // run through a wrap
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, (exp_cnt == MODULUS - 1) ? "R4" : "R3");

    // stop between ticks: hold
    pulse(1'b0, 1'b1);
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, "R5");

    // simultaneous start and stop while stopped: stays stopped
    pulse(1'b1, 1'b1);
    step(1'b0, 1'b0, "R6");

    // start coinciding with a tick: not counted, next one is
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R3");

    // stop coinciding with a tick: counted, then hold
    step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, "R8");

    // simultaneous pulses while running: stop wins
    pulse(1'b1, 1'b0);
    step(1'b0, 1'b0, "R3");
    pulse(1'b1, 1'b1);
    step(1'b0, 1'b0, "R6");

    // both on a tick while running: counted, then stopped
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, (exp_cnt == MODULUS - 1) ? "R4" : "R3");
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, "R6");

    // mid-run reset returns to stopped zero
    pulse(1'b1, 1'b0);
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, "R3");
    repeat (3) @(negedge clk_i);
    do_reset();
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R3", "expectations left over", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule